// File: doc/BRIEF.md
# Four-Beat Stored-Program CPU Core

This core runs a very small stored-program instruction set against a store of 32 words of 32 bits. Every instruction takes exactly four beats, in the fixed order Scan1, Action1, Scan2, Action2. An external strobe `beat_tick` moves the machine from one beat to the next, so the caller sets the pace. In Scan1 the program counter steps forward. In Action1 the word at the program counter is copied into the present-instruction register. In Scan2 the operand address and the function code are split out into two latches. In Action2 the instruction is carried out against the word at the latched address.

The store is held outside the core. The core drives one port of a RAM with a single cycle of read latency: an address, a write enable and write data, and it reads the data back. When the run switch is off, the beats keep turning and instructions are still fetched and latched for display. The accumulator, the program counter and the store are left untouched. A halt instruction lights the stop lamp and freezes execution in the same way. Turning the run switch off clears the halt.

Instruction layout: bits 4:0 hold the operand address and bits 15:13 hold the function code. All other bits are ignored. Function codes: 0 jumps to the address held in the operand word. 1 adds the operand word to the program counter. 2 loads the negated operand word. 3 stores the accumulator. 4 and 5 both subtract. 6 skips the next instruction when the accumulator is negative. 7 halts.

Top module: `ssc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the program counter, the present instruction and both latches clear, the beat returns to Scan1 (0) and the stop lamp goes off.
- R2: `beat_o` encodes Scan1=0, Action1=1, Scan2=2, Action2=3. It advances by exactly one, from 3 back to 0, on each clock edge where `beat_tick` is high, and it holds otherwise.
- R3: At the end of Scan1, when the machine is running, the 5-bit program counter increments by one, modulo 32.
- R4: At the end of Action1, the present instruction loads the store word at the program counter. At the end of Scan2, the address latch takes bits 4:0 and the function latch takes bits 15:13 of that word. The other 24 bits have no effect on execution.
- R5: Code 2 sets the accumulator to the two's-complement negation of the operand word. Codes 4 and 5 subtract the operand word from the accumulator. Both wrap modulo 2^32.
- R6: Code 3 writes the accumulator into the store at the latched address. It asserts `mem_we` for exactly one cycle, at the end of Action2.
- R7: Code 0 sets the program counter to the low 5 bits of the operand word. Code 1 adds those 5 bits to the program counter. The next fetch then uses that value plus one.
- R8: Code 6 increments the program counter once more when accumulator bit 31 is set, which skips one instruction. Otherwise it has no effect.
- R9: Code 7 turns on `stop_lamp`. While the lamp is on, no instruction changes the accumulator, the program counter or the store. A clock edge with `run_sw` low turns the lamp off.
- R10: With `run_sw` low, the beats still advance and instructions are still fetched and latched, but the accumulator, the program counter and the store do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_tick | input | 1 | One-cycle strobe that ends the current beat |
| run_sw | input | 1 | Run (1) or stop (0) switch |
| mem_addr | output | 5 | Store address: the program counter, or the address latch during Action2 |
| mem_we | output | 1 | Store write enable |
| mem_wdata | output | 32 | Store write data (the accumulator) |
| mem_rdata | input | 32 | Store read data, one cycle after the address |
| stop_lamp | output | 1 | Halted indicator |
| beat_o | output | 2 | Current beat |
| acc_o | output | 32 | Accumulator |
| pc_o | output | 5 | Program counter |
| pi_o | output | 32 | Present instruction |
| addr_latch_o | output | 5 | Operand address latch |
| func_latch_o | output | 3 | Function code latch |

## Verification
A corrupted beat counter shows up on `beat_o` at the very next strobe. It also moves the fetch, the latch load or the execute into the wrong beat, and the displayed registers reveal this within one instruction. A wrong program counter or a wrong accumulator appears on `pc_o` or `acc_o` at the end of the beat that updates it. The fetch then goes to the wrong word, so the error spreads into `pi_o` and the latches on the following instruction. A wrong halt or run state shows up as a change to the program counter or the store during a stopped instruction. It can also show up as a stop lamp that fails to change, within one instruction.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int FN_W   = 3;
    localparam int FN_LSB = 13;
    localparam int NBEATS = 4;

    typedef enum logic [1:0] {
        BT_SCAN1 = 2'd0,
        BT_ACT1  = 2'd1,
        BT_SCAN2 = 2'd2,
        BT_ACT2  = 2'd3
    } beat_e;

    typedef enum logic [FN_W-1:0] {
        FN_JMP  = 3'd0,
        FN_JRP  = 3'd1,
        FN_LDN  = 3'd2,
        FN_STO  = 3'd3,
        FN_SUB  = 3'd4,
        FN_SUBB = 3'd5,
        FN_CMP  = 3'd6,
        FN_HLT  = 3'd7
    } fn_e;

    function automatic beat_e next_beat(beat_e b);
        return beat_e'(b + 2'd1);
    endfunction

endpackage

// File: rtl/ssc_beat_seq.sv
module ssc_beat_seq
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_tick,
    output beat_e             beat,
    output logic [NBEATS-1:0] beat_end
);

    always_ff @(posedge clk) begin
        if (rst)
            beat <= BT_SCAN1;
        else if (beat_tick)
            beat <= next_beat(beat);
    end

    for (genvar g = 0; g < NBEATS; g++) begin : g_end
        assign beat_end[g] = beat_tick && (beat == beat_e'(g));
    end

    a_r2_beat_step: assert property (@(posedge clk) disable iff (rst)
        beat_tick |=> beat == beat_e'($past(beat) + 2'd1));

    a_r2_beat_hold: assert property (@(posedge clk) disable iff (rst)
        !beat_tick |=> $stable(beat));

endmodule

// File: rtl/ssc_fetch.sv
module ssc_fetch
    import ssc_pkg::*;
#(
    parameter int DW  = WORD_W,
    parameter int AW  = ADDR_W,
    parameter int FLS = FN_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_pi,
    input  logic          ld_latch,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] pi,
    output logic [AW-1:0] addr_lat,
    output fn_e           fn_lat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pi       <= '0;
            addr_lat <= '0;
            fn_lat   <= FN_JMP;
        end else begin
            if (ld_pi)
                pi <= rdata;
            if (ld_latch) begin
                addr_lat <= pi[AW-1:0];
                fn_lat   <= fn_e'(pi[FLS +: FN_W]);
            end
        end
    end

    a_r4_pi_only_act1: assert property (@(posedge clk) disable iff (rst)
        !ld_pi |=> $stable(pi));

    a_r4_latch_only_scan2: assert property (@(posedge clk) disable iff (rst)
        !ld_latch |=> $stable(addr_lat) && $stable(fn_lat));

endmodule

// File: rtl/ssc_exec.sv
module ssc_exec
    import ssc_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_sw,
    input  logic          inc_pc,
    input  logic          do_exec,
    input  fn_e           fn,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          halted,
    output logic          store_we
);

    logic run_en;
    assign run_en   = run_sw && !halted;
    assign store_we = do_exec && run_en && (fn == FN_STO);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            pc     <= '0;
            halted <= 1'b0;
        end else begin
            if (!run_sw)
                halted <= 1'b0;
            if (inc_pc && run_en)
                pc <= pc + 1'b1;
            if (do_exec && run_en) begin
                unique case (fn)
                    FN_JMP:          pc     <= operand[AW-1:0];
                    FN_JRP:          pc     <= pc + operand[AW-1:0];
                    FN_LDN:          acc    <= '0 - operand;
                    FN_SUB, FN_SUBB: acc    <= acc - operand;
                    FN_CMP:          if (acc[DW-1]) pc <= pc + 1'b1;
                    FN_HLT:          halted <= 1'b1;
                    default:         ;
                endcase
            end
        end
    end

    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        inc_pc && run_en |=> pc == AW'($past(pc) + 1'b1));

    a_r10_stop_freeze: assert property (@(posedge clk) disable iff (rst)
        !run_sw |=> $stable(acc) && $stable(pc));

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted && run_sw |=> halted);

    a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(acc));

endmodule

// File: rtl/ssc_core.sv
module ssc_core
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_tick,
    input  logic              run_sw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              stop_lamp,
    output logic [1:0]        beat_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] pi_o,
    output logic [ADDR_W-1:0] addr_latch_o,
    output logic [FN_W-1:0]   func_latch_o
);

    beat_e              beat;
    logic [NBEATS-1:0]  beat_end;
    logic [ADDR_W-1:0]  addr_lat;
    fn_e                fn_lat;
    logic [WORD_W-1:0]  acc;
    logic [ADDR_W-1:0]  pc;
    logic               halted;
    logic               store_we;

    ssc_beat_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .beat_tick(beat_tick),
        .beat     (beat),
        .beat_end (beat_end)
    );

    ssc_fetch #(.DW(WORD_W), .AW(ADDR_W), .FLS(FN_LSB)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .ld_pi   (beat_end[BT_ACT1]),
        .ld_latch(beat_end[BT_SCAN2]),
        .rdata   (mem_rdata),
        .pi      (pi_o),
        .addr_lat(addr_lat),
        .fn_lat  (fn_lat)
    );

    ssc_exec #(.DW(WORD_W), .AW(ADDR_W)) u_exec (
        .clk     (clk),
        .rst     (rst),
        .run_sw  (run_sw),
        .inc_pc  (beat_end[BT_SCAN1]),
        .do_exec (beat_end[BT_ACT2]),
        .fn      (fn_lat),
        .operand (mem_rdata),
        .acc     (acc),
        .pc      (pc),
        .halted  (halted),
        .store_we(store_we)
    );

    assign mem_addr     = (beat == BT_ACT2) ? addr_lat : pc;
    assign mem_we       = store_we;
    assign mem_wdata    = acc;
    assign stop_lamp    = halted;
    assign beat_o       = beat;
    assign acc_o        = acc;
    assign pc_o         = pc;
    assign addr_latch_o = addr_lat;
    assign func_latch_o = fn_lat;

    a_r6_write_in_act2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> beat == BT_ACT2 && beat_tick && run_sw && !stop_lamp);

    a_r6_write_single: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

// File: tb/ssc_core_test.sv
module ssc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        beat_tick = 1'b0;
    logic        run_sw = 1'b1;
    logic [4:0]  mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        stop_lamp;
    logic [1:0]  beat_o;
    logic [31:0] acc_o;
    logic [4:0]  pc_o;
    logic [31:0] pi_o;
    logic [4:0]  addr_latch_o;
    logic [2:0]  func_latch_o;

    logic [31:0] mem [32];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    ssc_core uut (
        .clk(clk), .rst(rst), .beat_tick(beat_tick), .run_sw(run_sw),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .stop_lamp(stop_lamp), .beat_o(beat_o),
        .acc_o(acc_o), .pc_o(pc_o), .pi_o(pi_o),
        .addr_latch_o(addr_latch_o), .func_latch_o(func_latch_o)
    );

    function automatic logic [31:0] ins(input int fn, input int a);
        return (32'(fn) << 13) | 32'(a);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) beat_tick = 1'b1;
        @(negedge clk) beat_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic instr();
        repeat (4) strobe();
    endtask

    task automatic t_reset();
        chk("R1 acc", acc_o, 0);
        chk("R1 pc", 32'(pc_o), 0);
        chk("R1 beat", 32'(beat_o), 0);
        chk("R1 stop", 32'(stop_lamp), 0);
        chk("R1 pi", pi_o, 0);
    endtask

    // first instruction at word 1: LDN 20, beats traced one by one
    task automatic t_beats_fetch();
        repeat (3) @(negedge clk);
        chk("R2 hold without strobe", 32'(beat_o), 0);
        strobe();
        chk("R2 beat 1", 32'(beat_o), 1);
        chk("R3 pc after scan1", 32'(pc_o), 1);
        strobe();
        chk("R2 beat 2", 32'(beat_o), 2);
        chk("R4 pi after act1", pi_o, mem[1]);
        strobe();
        chk("R2 beat 3", 32'(beat_o), 3);
        chk("R4 addr latch", 32'(addr_latch_o), 20);
        chk("R4 func latch", 32'(func_latch_o), 2);
        strobe();
        chk("R2 beat wraps", 32'(beat_o), 0);
        chk("R5 load negated", acc_o, 32'hFFFF_FFFB);
    endtask

    task automatic t_sub_store();
        instr();
        chk("R5 subtract code4", acc_o, 32'hFFFF_FFF8);
        instr();
        chk("R6 store written", mem[22], 32'hFFFF_FFF8);
        chk("R6 pc after store", 32'(pc_o), 3);
    endtask

    task automatic t_skip();
        instr();
        chk("R8 skip when negative", 32'(pc_o), 5);
        instr();
        chk("R8 skipped word not run, pc", 32'(pc_o), 6);
        chk("R4 junk bits ignored, acc", acc_o, 32'd8);
        chk("R4 junk word fetched", pi_o, mem[6]);
        instr();
        chk("R8 no skip when positive", 32'(pc_o), 7);
    endtask

    task automatic t_jumps();
        instr();
        chk("R5 subtract code5", acc_o, 32'hFFFF_FFFE);
        instr();
        chk("R7 absolute jump", 32'(pc_o), 11);
        instr();
        chk("R7 relative jump", 32'(pc_o), 15);
    endtask

    task automatic t_halt();
        instr();
        chk("R9 lamp on", 32'(stop_lamp), 1);
        chk("R9 pc at halt", 32'(pc_o), 16);
        instr();
        chk("R9 pc frozen", 32'(pc_o), 16);
        chk("R9 acc frozen", acc_o, 32'hFFFF_FFFE);
        @(negedge clk) run_sw = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 lamp cleared by switch", 32'(stop_lamp), 0);
    endtask

    task automatic t_stop_mode();
        mem[16] = ins(3, 26);
        mem[26] = 32'h1234_5678;
        instr();
        chk("R10 beats cycle", 32'(beat_o), 0);
        chk("R10 fetch continues", pi_o, mem[16]);
        chk("R10 func latched", 32'(func_latch_o), 3);
        chk("R10 pc frozen", 32'(pc_o), 16);
        chk("R10 acc frozen", acc_o, 32'hFFFF_FFFE);
        chk("R10 store not written", mem[26], 32'h1234_5678);
        @(negedge clk) run_sw = 1'b1;
        instr();
        chk("R10 resumes", acc_o, 32'hFFFF_FFFB);
        chk("R3 pc resumes", 32'(pc_o), 17);
    endtask

    task automatic t_wrap();
        instr();
        chk("R5 negate most negative", acc_o, 32'h8000_0000);
        instr();
        chk("R5 subtract wraps", acc_o, 32'h7FFF_FFFF);
    endtask

    task automatic t_reset_mid();
        strobe();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 32'h0;
        mem[1]  = ins(2, 20);
        mem[2]  = ins(4, 21);
        mem[3]  = ins(3, 22);
        mem[4]  = ins(6, 0);
        mem[5]  = ins(7, 0);
        mem[6]  = ins(2, 22) | (32'h5A5A_0C40 & ~32'h0000_E01F);
        mem[7]  = ins(6, 0);
        mem[8]  = ins(5, 23);
        mem[9]  = ins(0, 24);
        mem[12] = ins(1, 25);
        mem[16] = ins(7, 0);
        mem[17] = ins(2, 20);
        mem[18] = ins(2, 27);
        mem[19] = ins(4, 28);
        mem[20] = 32'd5;
        mem[21] = 32'd3;
        mem[23] = 32'd10;
        mem[24] = 32'd11;
        mem[25] = 32'd3;
        mem[27] = 32'h8000_0000;
        mem[28] = 32'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_beats_fetch();
        t_sub_store();
        t_skip();
        t_jumps();
        t_halt();
        t_stop_mode();
        t_wrap();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule